// File: doc/BRIEF.md
# Raw Data Channel Filter

This block is one raw-data output channel of a serial camera packet decoder. It sees every decoded packet of the link as a stream of beats. Each beat carries a virtual channel, a data type, and flags that mark frame-start and frame-end short packets. The channel forwards only the payload beats whose virtual channel and data type match its configuration word. Everything else on the link passes it by. It also counts the bytes it forwards and reports a compact internal channel identifier derived from its configuration.

Two controls act only at frame boundaries. The first is a halt/resume command. The second is a periodic frame-drop pattern. Here a frame boundary is a matching frame-start packet. A command sent in the middle of a frame waits until the next frame start, so every frame is either delivered whole or suppressed whole. A frame-index counter walks over a programmable period. A frame is discarded when the pattern bit at its index is set. Period 1 with pattern 0 delivers every frame.

Top module: `rdc_channel`

## Requirements
- R1: The configuration word holds the data type in bits 21:16, the virtual channel in bits 26:22, a 2-bit channel index in bits 28:27 and the enable in bit 31. A payload beat is forwarded only when both its data type and its virtual channel match.
- R2: With `ext_vc_i` low, only bits 1:0 of the virtual channel are compared. With `ext_vc_i` high, all 5 bits are compared. The frame-start and frame-end matches follow the same rule.
- R3: `chan_id_o` equals {configured VC[3:0], channel index[1:0]}.
- R4: A forwarded beat appears on `out_valid_o`/`out_data_o` one clock after it is accepted, with unchanged data. There is no output in a cycle after one with no input beat.
- R5: While enable (bit 31) is low, no payload is forwarded and the byte counter holds its value.
- R6: A halt command (`halt_cmd_i`=0) has no effect until the next matching frame start. The frame in progress is still forwarded. From that frame start on, `halted_o` is 1 and no payload is forwarded.
- R7: A resume command (`halt_cmd_i`=1) takes effect only at the next matching frame start. `halted_o` changes only in the cycle after a frame-start beat.
- R8: The frame index is 0 after reset. It advances at each matching frame start and wraps to 0 when it reaches `drop_period_i`; a period of 0 behaves as 1. A frame whose pattern bit `drop_pattern_i[index]` is 1 is not forwarded.
- R9: `byte_cnt_o` starts at 0 and grows by DATA_W/8 for each forwarded beat. Otherwise it holds.
- R10: Frame-start and frame-end beats are never forwarded. Payload that arrives outside a frame (after frame end, before the next frame start) is not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_word_i | input | 32 | Channel configuration word |
| ext_vc_i | input | 1 | Compare all 5 virtual-channel bits |
| halt_cmd_valid_i | input | 1 | Halt/resume command strobe |
| halt_cmd_i | input | 1 | 0 = halt, 1 = resume, at next frame start |
| drop_pattern_i | input | PAT_W | Per-frame drop bits |
| drop_period_i | input | PER_W | Frame-index wrap value |
| in_valid_i | input | 1 | Input beat valid |
| in_vc_i | input | 5 | Beat virtual channel |
| in_dt_i | input | 6 | Beat data type |
| in_fs_i | input | 1 | Beat is a frame-start packet |
| in_fe_i | input | 1 | Beat is a frame-end packet |
| in_data_i | input | DATA_W | Payload data |
| out_valid_o | output | 1 | Forwarded beat valid |
| out_data_o | output | DATA_W | Forwarded data |
| chan_id_o | output | 6 | Internal channel identifier |
| byte_cnt_o | output | CNT_W | Forwarded byte count |
| halted_o | output | 1 | Channel is halted |

## Verification
The frame-pass flag, the halt state and the frame index all sit behind the frame-start beat. A wrong value in any of them stays hidden until the payload of the following frame. It then shows for the whole frame: every beat is missing or extra, and the byte counter is off by DATA_W/8 per beat. A wrong frame index shows as a drop sequence shifted or wrapped at the wrong length, and only across several frames. The tests therefore run frame sequences longer than the period. A match-logic error shows at once, one clock after the offending beat.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int DT_LSB  = 16;
  localparam int VC_LSB  = 22;
  localparam int IDX_LSB = 27;
  localparam int EN_BIT  = 31;

  typedef struct packed {
    logic       en;
    logic [1:0] idx;
    logic [4:0] vc;
    logic [5:0] dt;
  } rdc_cfg_t;

  function automatic rdc_cfg_t rdc_decode(input logic [31:0] w);
    rdc_cfg_t c;
    c.en  = w[EN_BIT];
    c.idx = w[IDX_LSB +: 2];
    c.vc  = w[VC_LSB +: 5];
    c.dt  = w[DT_LSB +: 6];
    return c;
  endfunction
endpackage

// File: rtl/rdc_match.sv
module rdc_match (
  input  logic [4:0] cfg_vc_i,
  input  logic [5:0] cfg_dt_i,
  input  logic       ext_vc_i,
  input  logic [4:0] in_vc_i,
  input  logic [5:0] in_dt_i,
  output logic       vc_hit_o,
  output logic       dt_hit_o
);
  always_comb begin
    if (ext_vc_i) vc_hit_o = (in_vc_i == cfg_vc_i);
    else          vc_hit_o = (in_vc_i[1:0] == cfg_vc_i[1:0]);
    dt_hit_o = (in_dt_i == cfg_dt_i);
  end
endmodule

// File: rtl/rdc_boundary_ctl.sv
module rdc_boundary_ctl #(
  parameter int PAT_W = 32,
  localparam int IDX_W = $clog2(PAT_W),
  localparam int PER_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fs_hit_i,
  input  logic             fe_hit_i,
  input  logic             cmd_valid_i,
  input  logic             cmd_i,
  input  logic [PAT_W-1:0] pattern_i,
  input  logic [PER_W-1:0] period_i,
  output logic             frame_open_o,
  output logic             frame_pass_o,
  output logic             halted_o
);
  logic             pend_q, pend_val_q;
  logic [IDX_W-1:0] idx_q;
  logic             halt_next;
  logic [PER_W-1:0] idx_inc;

  // command arriving with the frame start applies to that frame start
  always_comb begin
    halt_next = halted_o;
    if (cmd_valid_i)  halt_next = ~cmd_i;
    else if (pend_q)  halt_next = ~pend_val_q;
    idx_inc = PER_W'(idx_q) + PER_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      pend_val_q   <= 1'b0;
      halted_o     <= 1'b0;
      idx_q        <= '0;
      frame_open_o <= 1'b0;
      frame_pass_o <= 1'b0;
    end else begin
      if (fs_hit_i) begin
        pend_q       <= 1'b0;
        halted_o     <= halt_next;
        frame_open_o <= 1'b1;
        frame_pass_o <= ~halt_next & ~pattern_i[idx_q];
        idx_q        <= (idx_inc >= period_i) ? '0 : idx_inc[IDX_W-1:0];
      end else begin
        if (cmd_valid_i) begin
          pend_q     <= 1'b1;
          pend_val_q <= cmd_i;
        end
        if (fe_hit_i || !en_i) frame_open_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rdc_payload_gate.sv
module rdc_payload_gate #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  localparam int BEAT_BYTES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_hit_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [CNT_W-1:0]  byte_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      byte_cnt_o  <= '0;
    end else begin
      out_valid_o <= beat_hit_i;
      if (beat_hit_i) begin
        out_data_o <= data_i;
        byte_cnt_o <= byte_cnt_o + CNT_W'(BEAT_BYTES);
      end
    end
  end
endmodule

// File: rtl/rdc_channel.sv
module rdc_channel
  import rdc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int PAT_W  = 32,
  localparam int PER_W = $clog2(PAT_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       cfg_word_i,
  input  logic              ext_vc_i,
  input  logic              halt_cmd_valid_i,
  input  logic              halt_cmd_i,
  input  logic [PAT_W-1:0]  drop_pattern_i,
  input  logic [PER_W-1:0]  drop_period_i,
  input  logic              in_valid_i,
  input  logic [4:0]        in_vc_i,
  input  logic [5:0]        in_dt_i,
  input  logic              in_fs_i,
  input  logic              in_fe_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [5:0]        chan_id_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic              halted_o
);
  rdc_cfg_t cfg;
  logic vc_hit, dt_hit, fs_hit, fe_hit, beat_hit;
  logic frame_open, frame_pass;
  logic unused_cfg;

  assign cfg        = rdc_decode(cfg_word_i);
  assign unused_cfg = ^{cfg_word_i[15:0], cfg_word_i[30:29]};
  assign chan_id_o  = {cfg.vc[3:0], cfg.idx};

  rdc_match u_match (
    .cfg_vc_i (cfg.vc),
    .cfg_dt_i (cfg.dt),
    .ext_vc_i (ext_vc_i),
    .in_vc_i  (in_vc_i),
    .in_dt_i  (in_dt_i),
    .vc_hit_o (vc_hit),
    .dt_hit_o (dt_hit)
  );

  assign fs_hit   = cfg.en & in_valid_i & in_fs_i & vc_hit;
  assign fe_hit   = cfg.en & in_valid_i & in_fe_i & ~in_fs_i & vc_hit;
  assign beat_hit = cfg.en & in_valid_i & ~in_fs_i & ~in_fe_i & vc_hit & dt_hit
                  & frame_open & frame_pass;

  rdc_boundary_ctl #(.PAT_W(PAT_W)) u_bnd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (cfg.en),
    .fs_hit_i     (fs_hit),
    .fe_hit_i     (fe_hit),
    .cmd_valid_i  (halt_cmd_valid_i),
    .cmd_i        (halt_cmd_i),
    .pattern_i    (drop_pattern_i),
    .period_i     (drop_period_i),
    .frame_open_o (frame_open),
    .frame_pass_o (frame_pass),
    .halted_o     (halted_o)
  );

  rdc_payload_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .beat_hit_i  (beat_hit),
    .data_i      (in_data_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .byte_cnt_o  (byte_cnt_o)
  );
endmodule

// File: rtl/rdc_channel_chk.sv
module rdc_channel_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [31:0]      cfg_word_i,
  input logic             in_valid_i,
  input logic             in_fs_i,
  input logic             in_fe_i,
  input logic             out_valid_o,
  input logic [CNT_W-1:0] byte_cnt_o,
  input logic             halted_o
);
  localparam int BB = DATA_W / 8;

  a_r4_no_beat_no_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  a_r10_marker_not_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fs_i || in_fe_i) |=> !out_valid_o);

  a_r5_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_word_i[31] |=> !out_valid_o);

  a_r6_halted_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> !out_valid_o);

  a_r7_halt_at_fs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(halted_o) |-> $past(in_valid_i && in_fs_i));

  a_r9_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(byte_cnt_o));

  a_r9_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> byte_cnt_o == $past(byte_cnt_o) + CNT_W'(BB));
endmodule

bind rdc_channel rdc_channel_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_word_i  (cfg_word_i),
  .in_valid_i  (in_valid_i),
  .in_fs_i     (in_fs_i),
  .in_fe_i     (in_fe_i),
  .out_valid_o (out_valid_o),
  .byte_cnt_o  (byte_cnt_o),
  .halted_o    (halted_o)
);

// File: tb/sim_rdc_channel.sv
`timescale 1ns/1ps
module sim_rdc_channel;
  localparam int DATA_W = 32, CNT_W = 32, PAT_W = 32, PER_W = 6, BB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic ext_vc = 1'b0, cmd_v = 1'b0, cmd = 1'b0;
  logic [PAT_W-1:0] pat = '0;
  logic [PER_W-1:0] per = 6'd1;
  logic in_valid = 1'b0, in_fs = 1'b0, in_fe = 1'b0;
  logic [4:0] in_vc = '0;
  logic [5:0] in_dt = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic out_valid, halted;
  logic [DATA_W-1:0] out_data;
  logic [5:0] chan_id;
  logic [CNT_W-1:0] byte_cnt;

  int errors = 0, checks = 0;
  logic [CNT_W-1:0] exp_cnt = '0;
  bit done = 0;

  always #10 clk = ~clk;

  rdc_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PAT_W(PAT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_word_i(cfg_word), .ext_vc_i(ext_vc),
    .halt_cmd_valid_i(cmd_v), .halt_cmd_i(cmd), .drop_pattern_i(pat),
    .drop_period_i(per), .in_valid_i(in_valid), .in_vc_i(in_vc), .in_dt_i(in_dt),
    .in_fs_i(in_fs), .in_fe_i(in_fe), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data), .chan_id_o(chan_id),
    .byte_cnt_o(byte_cnt), .halted_o(halted));

  function automatic logic [31:0] mk_cfg(bit en, logic [1:0] idx, logic [4:0] vc, logic [5:0] dt);
    return {en, 2'b00, idx, vc, dt, 16'h0};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; cmd_v = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_cnt = '0;
  endtask

  // one input beat; checks the registered output after the capturing edge
  task automatic step(logic v, logic fs, logic fe, logic [4:0] vc, logic [5:0] dt,
                      logic [31:0] d, bit exp_pass, string tag);
    @(negedge clk);
    in_valid = v; in_fs = fs; in_fe = fe; in_vc = vc; in_dt = dt; in_data = d;
    @(posedge clk); #1;
    in_valid = 1'b0; cmd_v = 1'b0;
    if (exp_pass) exp_cnt += BB;
    chk({tag, " valid"}, {31'b0, out_valid}, {31'b0, exp_pass});
    if (exp_pass) chk({tag, " data"}, out_data, d);
    chk({tag, " count"}, byte_cnt, exp_cnt);
  endtask

  task automatic frame(logic [4:0] vc, logic [5:0] dt, bit pass, string tag);
    step(1, 1, 0, vc, dt, 32'h0, 0, {tag, " fs"});
    step(1, 0, 0, vc, dt, 32'hA5A5_0001, pass, tag);
    step(1, 0, 0, vc, dt, 32'h5A5A_0002, pass, tag);
    step(1, 0, 1, vc, dt, 32'h0, 0, {tag, " fe"});
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R9 reset count", byte_cnt, 0);
    chk("R4 reset valid", {31'b0, out_valid}, 0);
    chk("R6 reset halted", {31'b0, halted}, 0);
  endtask

  task automatic t_match();
    cfg_word = mk_cfg(1, 2'd1, 5'd2, 6'h2B); ext_vc = 0; per = 1; pat = 0;
    #1 chk("R3 chan id", {26'b0, chan_id}, 32'h09);
    step(1, 0, 0, 5'd2, 6'h2B, 32'h1111, 0, "R10 before fs");
    step(1, 1, 0, 5'd2, 6'h00, 32'h0, 0, "R10 fs marker");
    step(1, 0, 0, 5'd2, 6'h2B, 32'h1234, 1, "R1 match");
    step(0, 0, 0, 5'd2, 6'h2B, 32'h9999, 0, "R4 idle");
    step(1, 0, 0, 5'd2, 6'h2A, 32'h2222, 0, "R1 dt miss");
    step(1, 0, 0, 5'd3, 6'h2B, 32'h3333, 0, "R1 vc miss");
    step(1, 0, 0, 5'd2, 6'h2B, 32'hCAFE, 1, "R4 data");
    step(1, 0, 1, 5'd2, 6'h00, 32'h0, 0, "R10 fe marker");
    step(1, 0, 0, 5'd2, 6'h2B, 32'h4444, 0, "R10 after fe");
  endtask

  task automatic t_vcmode();
    cfg_word = mk_cfg(1, 2'd3, 5'd5, 6'h12); ext_vc = 0;
    #1 chk("R3 chan id ext", {26'b0, chan_id}, 32'h17);
    step(1, 1, 0, 5'd5, 6'h0, 32'h0, 0, "R2 fs");
    step(1, 0, 0, 5'd1, 6'h12, 32'h0101, 1, "R2 low bits only");
    step(1, 0, 0, 5'd5, 6'h12, 32'h0505, 1, "R2 exact");
    ext_vc = 1;
    step(1, 0, 0, 5'd1, 6'h12, 32'h0111, 0, "R2 ext alias");
    step(1, 0, 0, 5'd5, 6'h12, 32'h0555, 1, "R2 ext exact");
    step(1, 0, 1, 5'd5, 6'h0, 32'h0, 0, "R2 fe");
  endtask

  task automatic t_disable();
    cfg_word = mk_cfg(1, 2'd0, 5'd4, 6'h2C); ext_vc = 1;
    step(1, 1, 0, 5'd4, 6'h0, 32'h0, 0, "R5 fs");
    cfg_word[31] = 1'b0;
    step(1, 0, 0, 5'd4, 6'h2C, 32'h7777, 0, "R5 disabled");
    step(1, 0, 0, 5'd4, 6'h2C, 32'h7778, 0, "R5 disabled 2");
    cfg_word[31] = 1'b1;
    frame(5'd4, 6'h2C, 1, "R5 reenabled");
  endtask

  task automatic t_halt();
    cfg_word = mk_cfg(1, 2'd0, 5'd1, 6'h2B); ext_vc = 0; per = 1; pat = 0;
    step(1, 1, 0, 5'd1, 6'h0, 32'h0, 0, "R6 fs");
    @(negedge clk); cmd_v = 1; cmd = 0;
    step(1, 0, 0, 5'd1, 6'h2B, 32'h8001, 1, "R6 cmd mid frame");
    chk("R6 still running", {31'b0, halted}, 0);
    step(1, 0, 0, 5'd1, 6'h2B, 32'h8002, 1, "R6 frame continues");
    step(1, 0, 1, 5'd1, 6'h0, 32'h0, 0, "R6 fe");
    chk("R7 no change at fe", {31'b0, halted}, 0);
    step(1, 1, 0, 5'd1, 6'h0, 32'h0, 0, "R6 fs halt");
    chk("R6 halted at fs", {31'b0, halted}, 1);
    step(1, 0, 0, 5'd1, 6'h2B, 32'h8003, 0, "R6 halted beat");
    @(negedge clk); cmd_v = 1; cmd = 1;
    step(1, 0, 0, 5'd1, 6'h2B, 32'h8004, 0, "R7 resume pending");
    chk("R7 still halted", {31'b0, halted}, 1);
    step(1, 0, 1, 5'd1, 6'h0, 32'h0, 0, "R7 fe");
    frame(5'd1, 6'h2B, 1, "R7 resumed");
    chk("R7 running", {31'b0, halted}, 0);
  endtask

  task automatic t_drop();
    do_reset();
    cfg_word = mk_cfg(1, 2'd2, 5'd3, 6'h2A); ext_vc = 0;
    per = 6'd3; pat = 32'b010;
    frame(5'd3, 6'h2A, 1, "R8 idx0");
    frame(5'd3, 6'h2A, 0, "R8 idx1 drop");
    frame(5'd3, 6'h2A, 1, "R8 idx2");
    frame(5'd3, 6'h2A, 1, "R8 wrap idx0");
    frame(5'd3, 6'h2A, 0, "R8 wrap idx1 drop");
    do_reset();
    per = 6'd0; pat = 32'h1;
    frame(5'd3, 6'h2A, 0, "R8 period0 a");
    frame(5'd3, 6'h2A, 0, "R8 period0 b");
    per = 6'd1; pat = 32'h0;
    frame(5'd3, 6'h2A, 1, "R8 normal");
  endtask

  initial begin
    t_reset();
    t_match();
    t_vcmode();
    t_disable();
    t_halt();
    t_drop();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule